// File: doc/BRIEF.md
# Parallel Chien Search Error Corrector

This block finds and repairs up to two flipped bits in one 15-bit BCH(15,7) codeword. It receives the received word together with the three coefficients of a degree-two error locator polynomial over GF(2^4). It then tests whether each of the 15 bit positions is a root of that polynomial. It does not test one position per clock. P lanes test P consecutive positions in the same cycle, so the search finishes in ceil(15/P) cycles instead of 15.

Each lane multiplies the running locator terms by fixed field constants. Each such multiplier is only an XOR network. After every step, two more fixed multipliers advance the running terms by P positions. When the last step ends, the block does three things:
- It counts the roots it has found and compares that count with the degree of the polynomial.
- It drives the error mask and the corrected word.
- It raises a single-cycle done strobe.

If the root count disagrees with the degree, the word is flagged as uncorrectable and is passed through unchanged.

A request is issued by pulsing `start` while the block is idle. The results stay valid from the done strobe until the next done strobe.

Top module: `bch_chien_par`

## Requirements
- R1: `start` sampled high while `busy` is low captures `loc_c0..loc_c2` and `rx_word` and sets `busy` on the same edge. `start` sampled while `busy` is high is ignored, and the running search keeps its original operands.
- R2: `done` goes high exactly NSTEP = ceil(15/P) rising edges after the edge that accepted `start`. With the default P=4, this is the 4th edge.
- R3: `done` is high for exactly one cycle per accepted request.
- R4: Bit i of `err_mask` (i = 0..14) is set when c0 + c1·α^-i + c2·α^-2i = 0 in GF(2^4). Field elements are 4-bit, with bit k holding the coefficient of α^k. α is a root of x^4+x+1, so α^4 = α+1.
- R5: `corrected` equals the captured `rx_word` XOR `err_mask`.
- R6: The degree is 2 if c2≠0, otherwise 1 if c1≠0, otherwise 0. `uncorrectable` is set when the number of roots found differs from the degree. In that case `err_mask` is zero and `corrected` equals the received word.
- R7: Coefficients (1,0,0) give a zero mask, `uncorrectable` low, and `corrected` equal to `rx_word`.
- R8: `err_mask`, `corrected` and `uncorrectable` change only on the `done` cycle. They hold their values during a later search until its `done`.
- R9: Synchronous reset clears `busy`, `done`, `err_mask`, `corrected` and `uncorrectable` to zero.
- R10: Lane slots beyond position 14 in the last step are neither flagged nor counted. An error at position 0 is therefore corrected and not reported twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, accepted only while idle |
| loc_c0 | input | 4 | Locator coefficient of x^0 |
| loc_c1 | input | 4 | Locator coefficient of x^1 |
| loc_c2 | input | 4 | Locator coefficient of x^2 |
| rx_word | input | 15 | Received codeword |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion strobe |
| err_mask | output | 15 | Located error positions |
| corrected | output | 15 | Received word with the mask applied |
| uncorrectable | output | 1 | Root count differs from locator degree |

## Verification
The assertions assume that `start` is held for only one cycle, apart from the deliberate start-while-busy case. They also assume that the received word stays meaningful only through the capture edge, which is why the checker keeps its own copy taken at acceptance. The mask-weight property assumes that a correctable result can never carry more than two bits. The stimulus derives every locator either from one or two chosen error positions, or from hand-picked polynomials with no roots or a degenerate form. Expected masks come from a brute-force evaluation of all 15 positions in the bench.

// File: rtl/bch_chien_pkg.sv
package bch_chien_pkg;
  localparam int GF_M = 4;
  localparam int CW_N = 15;
  localparam logic [GF_M-1:0] GF_RED = 4'b0011;

  typedef logic [GF_M-1:0] gf_t;
  typedef logic [CW_N-1:0] cw_t;

  function automatic gf_t gf_mul(gf_t a, gf_t b);
    gf_t acc;
    gf_t sh;
    acc = '0;
    sh  = a;
    for (int k = 0; k < GF_M; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = sh[GF_M-1] ? ({sh[GF_M-2:0], 1'b0} ^ GF_RED) : {sh[GF_M-2:0], 1'b0};
    end
    return acc;
  endfunction

  function automatic gf_t gf_alpha(int e);
    int  n;
    gf_t r;
    n = e % CW_N;
    if (n < 0) n = n + CW_N;
    r = gf_t'(1);
    for (int k = 0; k < n; k++) r = gf_mul(r, gf_t'(2));
    return r;
  endfunction
endpackage

// File: rtl/bch_chien_cmul.sv
module bch_chien_cmul
  import bch_chien_pkg::*;
#(
  parameter int EXP = 0
) (
  input  gf_t din,
  output gf_t dout
);
  localparam gf_t KCONST = gf_alpha(EXP);

  always_comb begin
    dout = '0;
    for (int c = 0; c < GF_M; c++) begin
      if (din[c]) dout = dout ^ gf_mul(KCONST, gf_t'(1 << c));
    end
  end
endmodule

// File: rtl/bch_chien_lane.sv
module bch_chien_lane
  import bch_chien_pkg::*;
#(
  parameter int LANE = 0
) (
  input  gf_t  c0,
  input  gf_t  t1,
  input  gf_t  t2,
  output logic hit
);
  gf_t p1;
  gf_t p2;

  bch_chien_cmul #(.EXP(-LANE))     u_m1 (.din(t1), .dout(p1));
  bch_chien_cmul #(.EXP(-2 * LANE)) u_m2 (.din(t2), .dout(p2));

  assign hit = ((c0 ^ p1 ^ p2) == '0);
endmodule

// File: rtl/bch_chien_par.sv
module bch_chien_par
  import bch_chien_pkg::*;
#(
  parameter int P = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [GF_M-1:0]      loc_c0,
  input  logic [GF_M-1:0]      loc_c1,
  input  logic [GF_M-1:0]      loc_c2,
  input  logic [CW_N-1:0]      rx_word,
  output logic                 busy,
  output logic                 done,
  output logic [CW_N-1:0]      err_mask,
  output logic [CW_N-1:0]      corrected,
  output logic                 uncorrectable
);
  localparam int NSTEP = (CW_N + P - 1) / P;
  localparam int SW    = (NSTEP > 1) ? $clog2(NSTEP) : 1;
  localparam int CNTW  = $clog2(CW_N + 1) + 1;

  gf_t             c0_q, t1_q, t2_q;
  gf_t             t1_nx, t2_nx;
  cw_t             rx_q, acc_q, mask_q, corr_q;
  logic [CNTW-1:0] cnt_q;
  logic [1:0]      deg_q;
  logic [SW-1:0]   step_q;
  logic            busy_q, done_q, unc_q;

  logic [P-1:0]    hit;
  cw_t             lane_mask, mask_full, mask_keep;
  logic [CNTW-1:0] lane_cnt, cnt_full;
  logic            unc_now;
  logic [1:0]      deg_in;

  genvar j;
  generate
    for (j = 0; j < P; j++) begin : g_lane
      bch_chien_lane #(.LANE(j)) u_lane (
        .c0 (c0_q),
        .t1 (t1_q),
        .t2 (t2_q),
        .hit(hit[j])
      );
    end
  endgenerate

  bch_chien_cmul #(.EXP(-P))     u_step1 (.din(t1_q), .dout(t1_nx));
  bch_chien_cmul #(.EXP(-2 * P)) u_step2 (.din(t2_q), .dout(t2_nx));

  always_comb begin
    lane_mask = '0;
    lane_cnt  = '0;
    for (int k = 0; k < P; k++) begin
      if (hit[k] && ((int'(step_q) * P + k) < CW_N)) begin
        lane_mask = lane_mask | (cw_t'(1) << (int'(step_q) * P + k));
        lane_cnt  = lane_cnt + CNTW'(1);
      end
    end
  end

  assign mask_full = acc_q | lane_mask;
  assign cnt_full  = cnt_q + lane_cnt;
  assign unc_now   = (cnt_full != CNTW'(deg_q));
  assign mask_keep = unc_now ? '0 : mask_full;
  assign deg_in    = (loc_c2 != '0) ? 2'd2 : ((loc_c1 != '0) ? 2'd1 : 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      c0_q   <= '0;
      t1_q   <= '0;
      t2_q   <= '0;
      rx_q   <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      deg_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      unc_q  <= 1'b0;
      mask_q <= '0;
      corr_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        c0_q   <= loc_c0;
        t1_q   <= loc_c1;
        t2_q   <= loc_c2;
        rx_q   <= rx_word;
        deg_q  <= deg_in;
        acc_q  <= '0;
        cnt_q  <= '0;
        step_q <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        t1_q   <= t1_nx;
        t2_q   <= t2_nx;
        acc_q  <= mask_full;
        cnt_q  <= cnt_full;
        step_q <= step_q + SW'(1);
        if (step_q == SW'(NSTEP - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          unc_q  <= unc_now;
          mask_q <= mask_keep;
          corr_q <= rx_q ^ mask_keep;
        end
      end
    end
  end

  assign busy          = busy_q;
  assign done          = done_q;
  assign err_mask      = mask_q;
  assign corrected     = corr_q;
  assign uncorrectable = unc_q;
endmodule

// File: rtl/bch_chien_par_chk.sv
module bch_chien_par_chk
  import bch_chien_pkg::*;
#(
  parameter int P = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic [CW_N-1:0] rx_word,
  input logic            busy,
  input logic            done,
  input logic [CW_N-1:0] err_mask,
  input logic [CW_N-1:0] corrected,
  input logic            uncorrectable
);
  localparam int NSTEP = (CW_N + P - 1) / P;

  logic [4:0]      lat_q;
  logic [CW_N-1:0] rx_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q  <= '0;
      rx_cap <= '0;
    end else if (start && !busy) begin
      lat_q  <= '0;
      rx_cap <= rx_word;
    end else if (busy) begin
      lat_q <= lat_q + 5'd1;
    end
  end

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R1
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_q == 5'(NSTEP))); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3
  AST_MASK_WEIGHT: assert property (@(posedge clk) disable iff (rst)
    (done && !uncorrectable) |-> ($countones(err_mask) <= 2)); // R4
  AST_CORR_APPLY: assert property (@(posedge clk) disable iff (rst)
    done |-> (corrected == (rx_cap ^ err_mask))); // R5
  AST_UNC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (done && uncorrectable) |-> (err_mask == '0)); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(err_mask) && $stable(corrected) && $stable(uncorrectable))); // R8
endmodule

bind bch_chien_par bch_chien_par_chk #(.P(P)) u_chk (.*);

// File: tb/bch_chien_par_tb.sv
`timescale 1ns/1ps
module bch_chien_par_tb;
  localparam int P     = 4;
  localparam int NSTEP = (15 + P - 1) / P;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  c0 = '0, c1 = '0, c2 = '0;
  logic [14:0] rx = '0;
  logic        busy, done, unc;
  logic [14:0] mask, corr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bch_chien_par #(.P(P)) u_dut (
    .clk(clk), .rst(rst), .start(start),
    .loc_c0(c0), .loc_c1(c1), .loc_c2(c2), .rx_word(rx),
    .busy(busy), .done(done), .err_mask(mask), .corrected(corr),
    .uncorrectable(unc)
  );

  function automatic logic [3:0] xt(logic [3:0] x);
    return {x[2:0], 1'b0} ^ (x[3] ? 4'b0011 : 4'b0000);
  endfunction

  function automatic logic [3:0] fmul(logic [3:0] a, logic [3:0] b);
    logic [3:0] r = '0;
    for (int k = 3; k >= 0; k--) begin
      r = xt(r);
      if (b[k]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [3:0] apow(int e);
    logic [3:0] r = 4'd1;
    for (int k = 0; k < ((e % 15) + 15) % 15; k++) r = xt(r);
    return r;
  endfunction

  task automatic ref_model(input logic [3:0] a0, a1, a2,
                           output logic [14:0] em, output logic eu);
    int n = 0;
    int dg;
    logic [3:0] iv;
    em = '0;
    for (int i = 0; i < 15; i++) begin
      iv = apow(15 - i);
      if ((a0 ^ fmul(a1, iv) ^ fmul(a2, fmul(iv, iv))) == 4'd0) begin
        em[i] = 1'b1;
        n++;
      end
    end
    dg = (a2 != 0) ? 2 : ((a1 != 0) ? 1 : 0);
    eu = (n != dg);
    if (eu) em = '0;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_search(input logic [3:0] a0, a1, a2, input logic [14:0] w,
                            input string req);
    logic [14:0] em;
    logic eu;
    ref_model(a0, a1, a2, em, eu);
    @(negedge clk);
    c0 = a0; c1 = a1; c2 = a2; rx = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R1", "busy after accept", 32'(busy), 32'd1);
    for (int k = 1; k <= NSTEP; k++) begin
      @(negedge clk);
      check(done == (k == NSTEP), "R2", "done timing", 32'(done), 32'(k == NSTEP));
    end
    check(mask == em, req, "err_mask", 32'(mask), 32'(em));
    check(unc == eu, "R6", "uncorrectable", 32'(unc), 32'(eu));
    check(corr == (w ^ em), "R5", "corrected", 32'(corr), 32'(w ^ em));
    @(negedge clk);
    check(done == 1'b0, "R3", "done width", 32'(done), 32'd0);
  endtask

  task automatic test_reset();
    check(busy == 0 && done == 0 && unc == 0, "R9", "reset flags",
          32'({busy, done, unc}), 32'd0);
    check(mask == 0 && corr == 0, "R9", "reset words",
          32'({mask, corr}), 32'd0);
  endtask

  task automatic test_no_error();
    run_search(4'd1, 4'd0, 4'd0, 15'h5A3C, "R7");
    check(mask == 0 && unc == 0, "R7", "clean word", 32'({unc, mask}), 32'd0);
  endtask

  task automatic test_single();
    for (int i = 0; i < 15; i++) begin
      run_search(4'd1, apow(i), 4'd0, 15'h1234, (i == 0) ? "R10" : "R4");
      check(mask == (15'd1 << i), "R4", "single position", 32'(mask), 32'(15'd1 << i));
    end
  endtask

  task automatic test_double();
    int pa[4] = '{0, 3, 5, 1};
    int pb[4] = '{14, 7, 6, 12};
    for (int q = 0; q < 4; q++) begin
      run_search(4'd1, apow(pa[q]) ^ apow(pb[q]), apow(pa[q] + pb[q]), 15'h7F00, "R4");
      check(mask == ((15'd1 << pa[q]) | (15'd1 << pb[q])), "R4", "double position",
            32'(mask), 32'((15'd1 << pa[q]) | (15'd1 << pb[q])));
    end
  endtask

  task automatic test_uncorrectable();
    run_search(4'd1, 4'd1, 4'b1000, 15'h2AAA, "R6");
    check(unc == 1'b1 && corr == 15'h2AAA, "R6", "rootless quadratic",
          32'({unc, corr}), 32'({1'b1, 15'h2AAA}));
    run_search(4'd0, 4'd0, 4'd0, 15'h0F0F, "R6");
    check(unc == 1'b1, "R6", "all-zero locator", 32'(unc), 32'd1);
    run_search(4'd0, 4'd3, 4'd0, 15'h0101, "R6");
    check(unc == 1'b1, "R6", "degree one no root", 32'(unc), 32'd1);
  endtask

  task automatic test_busy_ignore();
    @(negedge clk);
    c0 = 4'd1; c1 = apow(4); c2 = 4'd0; rx = 15'h0000; start = 1'b1;
    @(negedge clk);
    c0 = 4'd1; c1 = apow(9); c2 = 4'd0; rx = 15'h7FFF;
    @(negedge clk);
    start = 1'b0;
    for (int k = 2; k <= NSTEP; k++) @(negedge clk);
    check(done == 1'b1, "R1", "done after ignored start", 32'(done), 32'd1);
    check(mask == 15'h0010 && corr == 15'h0010, "R1", "first request kept",
          32'({mask, corr}), 32'({15'h0010, 15'h0010}));
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1", "no second search",
          32'({busy, done}), 32'd0);
  endtask

  task automatic test_hold();
    logic [14:0] om, oc;
    logic ou;
    run_search(4'd1, apow(2) ^ apow(11), apow(13), 15'h3C3C, "R4");
    om = mask; oc = corr; ou = unc;
    repeat (3) @(negedge clk);
    check(mask == om && corr == oc && unc == ou, "R8", "idle hold",
          32'(mask), 32'(om));
    c0 = 4'd1; c1 = 4'd1; c2 = 4'b1000; rx = 15'h0001; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k < NSTEP; k++) begin
      @(negedge clk);
      check(mask == om && corr == oc && unc == ou, "R8", "hold during search",
            32'(mask), 32'(om));
    end
    @(negedge clk);
    check(unc == 1'b1 && corr == 15'h0001, "R8", "update on done",
          32'({unc, corr}), 32'({1'b1, 15'h0001}));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    test_reset();
    rst = 1'b0;
    test_no_error();
    test_single();
    test_double();
    test_uncorrectable();
    test_busy_ignore();
    test_hold();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule